// File: doc/BRIEF.md
# Multi-core interrupt source router

This block gathers the interrupt sources of a small processor cluster and steers each one to the normal-interrupt (IRQ) line or the fast-interrupt (FIQ) line of one of `NCORE` cores. Every core contributes four timer lines, four mailbox-pending flags and a pair of already-resolved local-timer requests. A single upstream IRQ line and a single upstream FIQ line arrive from a downstream interrupt controller. Each of those two can be aimed at its own target core.

For every core the block builds two 32-bit source words, one for IRQ and one for FIQ. Each set bit names the source that is currently asserting. A core's interrupt output is simply the OR of its word. Software sets the per-source enables and the upstream targets through a 32-bit register port, and it can read both source words back. The source words are computed combinationally from the live input levels. A source that drops therefore disappears from the word and from the output at once.

Top module: `irq_core_router`

## Requirements
- R1: After reset, the upstream route register reads 0, so both upstream targets are core 0. Every timer-enable and mailbox-enable register reads 0.
- R2: A write to the timer-enable register of core c (offset 0x40 + 4·c) or to its mailbox-enable register (offset 0x50 + 4·c) stores only bits [7:0]. A read returns those 8 bits with bits [31:8] zero.
- R3: Timer line j (0..3) of core c sets bit j of that core's IRQ word when enable bit j is set and enable bit j+4 is clear. When enable bit j+4 is set, the line sets bit j of the FIQ word instead.
- R4: When both enable bits of a source are set, the source appears in the FIQ word only and never in the IRQ word.
- R5: When neither enable bit of a source is set, the source appears in neither word.
- R6: Mailbox flag j of core c is steered by that core's mailbox-enable register, using the same rule and bit layout as R3–R5. Its result lands at word bit 4+j.
- R7: The upstream IRQ line sets bit 8 of the IRQ word of the core chosen by route bits [1:0]. The upstream FIQ line sets bit 8 of the FIQ word of the core chosen by route bits [3:2]. No other core sees either line, and the enable registers do not affect them.
- R8: The route register sits at offset 0x0C. It keeps bits [3:0] of a write, and a read returns them in the same layout with all higher bits zero.
- R9: A core's local-timer IRQ request sets bit 11 of its IRQ word, and its local-timer FIQ request sets bit 11 of its FIQ word.
- R10: `core_irq[c]` is high exactly when core c's IRQ word is nonzero. `core_fiq[c]` follows the same rule with the FIQ word.
- R11: The IRQ words read at 0x60 + 4·c and the FIQ words read at 0x70 + 4·c. Both ranges are read-only: writing to them leaves every register unchanged. A word bit clears without a clock edge when its input falls.
- R12: A read of an undecoded or misaligned offset returns 0. A write there changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_line | input | 4·NCORE | Timer lines, core c at bits [4c+3:4c] |
| mbx_pend | input | 4·NCORE | Mailbox-pending flags, core c at bits [4c+3:4c] |
| ltmr_irq | input | NCORE | Local-timer IRQ request per core |
| ltmr_fiq | input | NCORE | Local-timer FIQ request per core |
| up_irq | input | 1 | Shared upstream IRQ line |
| up_fiq | input | 1 | Shared upstream FIQ line |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| core_irq | output | NCORE | IRQ output per core |
| core_fiq | output | NCORE | FIQ output per core |

## Verification
The bench builds the router with its default of four cores. At that size every register slot and every source-word offset is decoded, and all four values of each 2-bit route field name a real core. This makes a complete sweep affordable. On every core it drives each timer and mailbox source under all four enable combinations and both line levels. It walks all sixteen route codes against every pairing of the upstream lines and tries both local-timer requests on each core. After every step it compares all source words and outputs against values computed from the requirements.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef logic [31:0] word_t;

    // Source-word bit positions (decoded by software, so fixed)
    localparam int SRC_GRP   = 4;
    localparam int SRC_TMR0  = 0;
    localparam int SRC_MBX0  = 4;
    localparam int SRC_UP    = 8;
    localparam int SRC_LTMR  = 11;

    // Register map
    localparam logic [7:0] OFS_ROUTE = 8'h0C;
    localparam logic [3:0] RGN_TCTL  = 4'h4;
    localparam logic [3:0] RGN_MCTL  = 4'h5;
    localparam logic [3:0] RGN_ISRC  = 4'h6;
    localparam logic [3:0] RGN_FSRC  = 4'h7;

    localparam int CTL_W   = 8;
    localparam int ROUTE_W = 2;

endpackage

// File: rtl/irq_core_steer.sv
module irq_core_steer
    import irq_router_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CTL_W-1:0]     tmr_ctl,
    input  logic [CTL_W-1:0]     mbx_ctl,
    input  logic [SRC_GRP-1:0]   tmr_src,
    input  logic [SRC_GRP-1:0]   mbx_src,
    input  logic                 up_irq_hit,
    input  logic                 up_fiq_hit,
    input  logic                 lt_irq,
    input  logic                 lt_fiq,
    output word_t                irq_word,
    output word_t                fiq_word
);

    // FIQ enable in the upper nibble wins over IRQ enable in the lower one
    always_comb begin
        irq_word = '0;
        fiq_word = '0;
        for (int j = 0; j < SRC_GRP; j++) begin
            fiq_word[SRC_TMR0+j] = tmr_src[j] & tmr_ctl[SRC_GRP+j];
            irq_word[SRC_TMR0+j] = tmr_src[j] & tmr_ctl[j] & ~tmr_ctl[SRC_GRP+j];
            fiq_word[SRC_MBX0+j] = mbx_src[j] & mbx_ctl[SRC_GRP+j];
            irq_word[SRC_MBX0+j] = mbx_src[j] & mbx_ctl[j] & ~mbx_ctl[SRC_GRP+j];
        end
        irq_word[SRC_UP]   = up_irq_hit;
        fiq_word[SRC_UP]   = up_fiq_hit;
        irq_word[SRC_LTMR] = lt_irq;
        fiq_word[SRC_LTMR] = lt_fiq;
    end

    // R4: a locally steered source never shows up in both words
    a_r4_fiq_excludes_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_word[7:0] & fiq_word[7:0]) == 8'h00);

    // R5: with no timer enables set, timer bits stay clear in both words
    a_r5_timer_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ctl == '0) |-> (irq_word[3:0] == 4'h0 && fiq_word[3:0] == 4'h0));

    // R6: with no mailbox enables set, mailbox bits stay clear in both words
    a_r6_mbox_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mbx_ctl == '0) |-> (irq_word[7:4] == 4'h0 && fiq_word[7:4] == 4'h0));

endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_en,
    input  logic                          reg_we,
    input  logic [7:0]                    reg_addr,
    input  logic [31:0]                   reg_wdata,
    input  logic [NCORE-1:0][31:0]        irq_words,
    input  logic [NCORE-1:0][31:0]        fiq_words,
    output logic [ROUTE_W-1:0]            route_irq,
    output logic [ROUTE_W-1:0]            route_fiq,
    output logic [NCORE-1:0][CTL_W-1:0]   tmr_ctl,
    output logic [NCORE-1:0][CTL_W-1:0]   mbx_ctl,
    output logic [31:0]                   reg_rdata
);

    localparam int IDX_W = 2;

    logic [3:0]       region;
    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             idx_ok;
    logic             wr_route;
    logic             wr_tctl;
    logic             wr_mctl;
    logic [23:0]      wdata_unused;

    assign region       = reg_addr[7:4];
    assign idx          = reg_addr[3:2];
    assign aligned      = (reg_addr[1:0] == 2'b00);
    assign idx_ok       = (int'(idx) < NCORE);
    assign wr_route     = reg_en && reg_we && (reg_addr == OFS_ROUTE);
    assign wr_tctl      = reg_en && reg_we && aligned && idx_ok && (region == RGN_TCTL);
    assign wr_mctl      = reg_en && reg_we && aligned && idx_ok && (region == RGN_MCTL);
    assign wdata_unused = reg_wdata[31:8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_irq <= '0;
            route_fiq <= '0;
        end else if (wr_route) begin
            route_irq <= reg_wdata[1:0];
            route_fiq <= reg_wdata[3:2];
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_ctl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tmr_ctl[c] <= '0;
                mbx_ctl[c] <= '0;
            end else begin
                if (wr_tctl && int'(idx) == c) tmr_ctl[c] <= reg_wdata[CTL_W-1:0];
                if (wr_mctl && int'(idx) == c) mbx_ctl[c] <= reg_wdata[CTL_W-1:0];
            end
        end

        // R2: a write to this core's timer-enable slot lands in the low byte
        a_r2_tctl_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_en && reg_we && reg_addr == 8'(8'h40 + 4*c))
            |=> (tmr_ctl[c] == $past(reg_wdata[7:0])));
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_ROUTE) begin
            reg_rdata = {28'h0, route_fiq, route_irq};
        end else if (aligned && idx_ok) begin
            unique case (region)
                RGN_TCTL: reg_rdata = {24'h0, tmr_ctl[idx]};
                RGN_MCTL: reg_rdata = {24'h0, mbx_ctl[idx]};
                RGN_ISRC: reg_rdata = irq_words[idx];
                RGN_FSRC: reg_rdata = fiq_words[idx];
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R8: the route fields move only on a write to their own offset
    a_r8_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_route |=> $stable({route_fiq, route_irq}));

    // R11: writes into the source-word ranges leave all registers untouched
    a_r11_src_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && (region == RGN_ISRC || region == RGN_FSRC))
        |=> ($stable(tmr_ctl) && $stable(mbx_ctl) && $stable({route_fiq, route_irq})));

    // R12: offset zero is undecoded and reads as zero
    a_r12_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && reg_addr == 8'h00) |-> (reg_rdata == 32'h0));

endmodule

// File: rtl/irq_core_router.sv
module irq_core_router
    import irq_router_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SRC_GRP*NCORE-1:0] tmr_line,
    input  logic [SRC_GRP*NCORE-1:0] mbx_pend,
    input  logic [NCORE-1:0]         ltmr_irq,
    input  logic [NCORE-1:0]         ltmr_fiq,
    input  logic                     up_irq,
    input  logic                     up_fiq,
    input  logic                     reg_en,
    input  logic                     reg_we,
    input  logic [7:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic [NCORE-1:0]         core_irq,
    output logic [NCORE-1:0]         core_fiq
);

    logic [ROUTE_W-1:0]          route_irq;
    logic [ROUTE_W-1:0]          route_fiq;
    logic [NCORE-1:0][CTL_W-1:0] tmr_ctl;
    logic [NCORE-1:0][CTL_W-1:0] mbx_ctl;
    logic [NCORE-1:0][31:0]      irq_words;
    logic [NCORE-1:0][31:0]      fiq_words;
    logic [NCORE-1:0]            up_irq_hit;
    logic [NCORE-1:0]            up_fiq_hit;

    irq_router_regs #(.NCORE(NCORE)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .irq_words (irq_words),
        .fiq_words (fiq_words),
        .route_irq (route_irq),
        .route_fiq (route_fiq),
        .tmr_ctl   (tmr_ctl),
        .mbx_ctl   (mbx_ctl),
        .reg_rdata (reg_rdata)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        assign up_irq_hit[c] = up_irq && (route_irq == ROUTE_W'(c));
        assign up_fiq_hit[c] = up_fiq && (route_fiq == ROUTE_W'(c));

        irq_core_steer steer_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .tmr_ctl    (tmr_ctl[c]),
            .mbx_ctl    (mbx_ctl[c]),
            .tmr_src    (tmr_line[SRC_GRP*c +: SRC_GRP]),
            .mbx_src    (mbx_pend[SRC_GRP*c +: SRC_GRP]),
            .up_irq_hit (up_irq_hit[c]),
            .up_fiq_hit (up_fiq_hit[c]),
            .lt_irq     (ltmr_irq[c]),
            .lt_fiq     (ltmr_fiq[c]),
            .irq_word   (irq_words[c]),
            .fiq_word   (fiq_words[c])
        );

        assign core_irq[c] = |irq_words[c];
        assign core_fiq[c] = |fiq_words[c];

        // R10: a core output is high exactly when its word holds a source
        a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
            core_irq[c] == (irq_words[c] != 32'h0));
        a_r10_fiq_level: assert property (@(posedge clk) disable iff (!rst_n)
            core_fiq[c] == (fiq_words[c] != 32'h0));
    end

    // R7: each upstream line reaches at most one core
    a_r7_up_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(up_irq_hit) && $onehot0(up_fiq_hit));

endmodule

// File: tb/irq_core_router_tb_top.sv
`timescale 1ns/1ps
module irq_core_router_tb_top;

    localparam int NCORE = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4*NCORE-1:0] tmr_line = '0;
    logic [4*NCORE-1:0] mbx_pend = '0;
    logic [NCORE-1:0]  ltmr_irq = '0;
    logic [NCORE-1:0]  ltmr_fiq = '0;
    logic              up_irq = 1'b0;
    logic              up_fiq = 1'b0;
    logic              reg_en = 1'b0;
    logic              reg_we = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NCORE-1:0]  core_irq;
    logic [NCORE-1:0]  core_fiq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the programmed state
    logic [7:0] m_tctl [NCORE];
    logic [7:0] m_mctl [NCORE];
    logic [1:0] m_ri, m_rf;

    always #2.5 clk = ~clk;

    irq_core_router #(.NCORE(NCORE)) dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_line(tmr_line), .mbx_pend(mbx_pend),
        .ltmr_irq(ltmr_irq), .ltmr_fiq(ltmr_fiq), .up_irq(up_irq), .up_fiq(up_fiq),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_irq(core_irq), .core_fiq(core_fiq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    // steering rule: fiq enable at j+4 wins, irq enable at j, else masked
    function automatic logic [3:0] steer4(input logic [3:0] src, input logic [7:0] ctl, input bit f);
        logic [3:0] r;
        for (int j = 0; j < 4; j++)
            r[j] = f ? (src[j] & ctl[j+4]) : (src[j] & ctl[j] & ~ctl[j+4]);
        return r;
    endfunction

    function automatic logic [31:0] exp_word(input int c, input bit f);
        logic [31:0] w = '0;
        w[3:0] = steer4(tmr_line[4*c +: 4], m_tctl[c], f);
        w[7:4] = steer4(mbx_pend[4*c +: 4], m_mctl[c], f);
        w[8]   = f ? (up_fiq && m_rf == 2'(c)) : (up_irq && m_ri == 2'(c));
        w[11]  = f ? ltmr_fiq[c] : ltmr_irq[c];
        return w;
    endfunction

    task automatic verify_core(input int c, input string tag);
        logic [31:0] d;
        logic [31:0] ei, ef;
        ei = exp_word(c, 1'b0);
        ef = exp_word(c, 1'b1);
        rd(8'(8'h60 + 4*c), d); check({tag, " irq word"}, d, ei);
        rd(8'(8'h70 + 4*c), d); check({tag, " fiq word"}, d, ef);
        check("R10 core_irq", 32'(core_irq[c]), 32'(ei != 0));
        check("R10 core_fiq", 32'(core_fiq[c]), 32'(ef != 0));
    endtask

    task automatic verify_ctl(input string tag);
        logic [31:0] d;
        for (int c = 0; c < NCORE; c++) begin
            rd(8'(8'h40 + 4*c), d); check({tag, " tctl"}, d, 32'(m_tctl[c]));
            rd(8'(8'h50 + 4*c), d); check({tag, " mctl"}, d, 32'(m_mctl[c]));
        end
        rd(8'h0C, d); check({tag, " route"}, d, {28'h0, m_rf, m_ri});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        string tag;
        for (int c = 0; c < NCORE; c++) begin m_tctl[c] = '0; m_mctl[c] = '0; end
        m_ri = '0; m_rf = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        verify_ctl("R1");
        check("R1 outputs", {core_fiq, core_irq}, '0);

        // R2: only the low byte is kept
        wr(8'h44, 32'hFFFF_FFA5); m_tctl[1] = 8'hA5;
        wr(8'h58, 32'h1234_5677); m_mctl[2] = 8'h77;
        verify_ctl("R2");
        wr(8'h44, 0); m_tctl[1] = 0;
        wr(8'h58, 0); m_mctl[2] = 0;

        // R3/R4/R5: timer sources, all enable combinations, both levels
        for (int c = 0; c < NCORE; c++)
            for (int j = 0; j < 4; j++)
                for (int en = 0; en < 4; en++)
                    for (int lv = 0; lv < 2; lv++) begin
                        m_tctl[c] = 8'(((en & 1) << j) | (((en >> 1) & 1) << (j + 4)));
                        wr(8'(8'h40 + 4*c), 32'(m_tctl[c]));
                        @(negedge clk); tmr_line[4*c + j] = lv[0];
                        tag = (en == 3) ? "R4" : (en == 0) ? "R5" : "R3";
                        verify_core(c, tag);
                        tmr_line = '0;
                    end
        for (int c = 0; c < NCORE; c++) begin m_tctl[c] = 0; wr(8'(8'h40 + 4*c), 0); end

        // R6: mailbox sources
        for (int c = 0; c < NCORE; c++)
            for (int j = 0; j < 4; j++)
                for (int en = 0; en < 4; en++)
                    for (int lv = 0; lv < 2; lv++) begin
                        m_mctl[c] = 8'(((en & 1) << j) | (((en >> 1) & 1) << (j + 4)));
                        wr(8'(8'h50 + 4*c), 32'(m_mctl[c]));
                        @(negedge clk); mbx_pend[4*c + j] = lv[0];
                        verify_core(c, "R6");
                        mbx_pend = '0;
                    end
        for (int c = 0; c < NCORE; c++) begin m_mctl[c] = 0; wr(8'(8'h50 + 4*c), 0); end

        // R7/R8: every route code against every upstream pairing
        for (int r = 0; r < 16; r++) begin
            wr(8'h0C, 32'hDEAD_BEE0 | 32'(r));
            m_ri = 2'(r); m_rf = 2'(r >> 2);
            rd(8'h0C, d); check("R8 route readback", d, 32'(r));
            for (int u = 0; u < 4; u++) begin
                @(negedge clk); up_irq = u[0]; up_fiq = u[1];
                for (int c = 0; c < NCORE; c++) verify_core(c, "R7");
            end
            up_irq = 0; up_fiq = 0;
        end

        // R9: local-timer requests
        for (int c = 0; c < NCORE; c++)
            for (int u = 1; u < 4; u++) begin
                @(negedge clk); ltmr_irq[c] = u[0]; ltmr_fiq[c] = u[1];
                for (int k = 0; k < NCORE; k++) verify_core(k, "R9");
                ltmr_irq = '0; ltmr_fiq = '0;
            end

        // R11: source ranges read-only; bits follow live levels
        m_tctl[0] = 8'h21; wr(8'h40, 32'h21);
        m_mctl[3] = 8'h84; wr(8'h5C, 32'h84);
        @(negedge clk); tmr_line[0] = 1; tmr_line[1] = 1; mbx_pend[14] = 1; mbx_pend[15] = 1;
        wr(8'h60, 32'hFFFF_FFFF); wr(8'h74, 32'hFFFF_FFFF); wr(8'h6C, 32'h0);
        verify_ctl("R11");
        verify_core(0, "R11"); verify_core(3, "R11");
        @(negedge clk); tmr_line[1] = 0;
        #1 check("R11 live drop fiq0", 32'(core_fiq[0]), 32'h0);
        verify_core(0, "R11");

        // R12: holes and misaligned offsets
        wr(8'h00, 32'hFF); wr(8'h10, 32'hFF); wr(8'h30, 32'hFF);
        wr(8'h80, 32'hFF); wr(8'hC4, 32'hFF); wr(8'h41, 32'hFF); wr(8'h0D, 32'hFF);
        rd(8'h00, d); check("R12 read 0x00", d, 0);
        rd(8'h80, d); check("R12 read 0x80", d, 0);
        rd(8'h41, d); check("R12 read 0x41", d, 0);
        rd(8'hFC, d); check("R12 read 0xFC", d, 0);
        verify_ctl("R12");
        for (int c = 0; c < NCORE; c++) verify_core(c, "R12");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule